// File: doc/BRIEF.md
# H-Bridge PWM Channel Pair

This block drives motor or gauge coils from a pair of PWM channels that share one free-running period counter. Each channel owns a plus pin and a minus pin, and each pin has its own output-enable. A per-channel mode field puts the channel in one of four settings: disabled, half-bridge, full-bridge or dual full-bridge. In the full-bridge settings a sign bit in the duty register chooses which of the two pins carries the PWM waveform. A recirculation bit sets the level that the other pin is held at, and also sets the polarity of the waveform. In half-bridge mode only the plus pin is driven. The minus pin is released to whatever else shares it.

Software programs the block through a small write port. Mode and recirculation changes act at once. Duty and sign writes go into a shadow copy and move to the active copy only at a period boundary, so a waveform period is never cut short. In dual full-bridge mode the two channels of a pair form one unit: a new duty or sign on one channel waits until its partner has also been written, and then both change on the same boundary. A stepper or a 360-degree gauge therefore never sees a half-updated vector.

Top module: `hbridge_pwm_pair`

## Requirements
- R1: While reset is asserted, and immediately after it, every pin and every output-enable is low, and every channel is in the disabled mode.
- R2: A channel whose mode field is 0 (disabled) keeps both output-enables and both pins low, whatever its duty register holds.
- R3: The period counter starts at 0 in the first cycle after reset, counts up by one each cycle and wraps from 255 to 0. The raw PWM signal of a channel is high while the counter is below the 8-bit duty magnitude, so a duty of 0 never goes high and over any 256 consecutive cycles the raw signal is high for exactly duty cycles.
- R4: In full-bridge (mode 2) and dual full-bridge (mode 3), both output-enables are high. Sign 0 puts the waveform on the plus pin and holds the minus pin static. Sign 1 does the reverse.
- R5: With recirculation 0 the static pin is low and the waveform is active-high. With recirculation 1 the static pin is high and the waveform is inverted, so the waveform pin is low for duty cycles per period.
- R6: In half-bridge (mode 1) the plus pin carries the active-high raw PWM signal with its enable high. The minus pin has its enable low and drives low. Both the sign bit and the recirculation bit are ignored.
- R7: A duty or sign write takes effect in the first cycle of the next period (counter 0) and not earlier. In full-bridge mode each channel updates on its own.
- R8: When both channels of a pair are in dual full-bridge mode, a channel's new duty and sign are held back until both channels have been written since their last update. Both then take effect at the same period boundary.
- R9: A mode or recirculation write changes the pins in the cycle after the write edge.
- R10: Address bit 1 selects control (0) or duty (1), and address bit 0 selects the channel. Control data holds mode in bits 1:0 and recirculation in bit 2. Duty data holds the sign in bit 8 and the magnitude in bits 7:0. A write to one channel leaves the other channel's outputs unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Bit 1: control/duty select; bit 0: channel |
| wr_data | input | 9 | Write data (control or duty layout) |
| pin_p | output | 2 | Plus pin level, one bit per channel |
| pin_m | output | 2 | Minus pin level, one bit per channel |
| oe_p | output | 2 | Plus pin output-enable, one bit per channel |
| oe_m | output | 2 | Minus pin output-enable, one bit per channel |

## Verification
Full-bridge mode is swept over seventeen-step duty values plus 1 and 128, with every sign and recirculation combination, and the high time of both pins is counted over one whole period. That sweep separates a swapped pin choice, a missing inversion and a wrong static level. A similar sweep runs in half-bridge mode with the sign and recirculation bits set, which shows that they are ignored. Phase-aligned probes at chosen counter values show whether a duty write lands too early or too late. In dual mode a write to a single channel must leave the old waveform in place, and the second write must move both channels on the same boundary.

// File: rtl/hbp_pkg.sv
// Shared types for the H-bridge PWM pair.
// Assumes: mode encoding is fixed by the register layout.
package hbp_pkg;
    typedef enum logic [1:0] {
        HB_OFF  = 2'd0,
        HB_HALF = 2'd1,
        HB_FULL = 2'd2,
        HB_DUAL = 2'd3
    } hb_mode_e;
endpackage

// File: rtl/hbp_timebase.sv
// Free-running period counter shared by all channels.
// Assumes: the period is 2**W cycles; wrap flags the last count of a period.
module hbp_timebase #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    output logic [W-1:0] cnt_q,
    output logic         wrap
);
    localparam logic [W-1:0] CNT_MAX = {W{1'b1}};

    // Counts up every cycle and wraps naturally.
    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_q + 1'b1;
    end

    // Marks the cycle after which a new period starts.
    assign wrap = (cnt_q == CNT_MAX);
endmodule

// File: rtl/hbp_duty_bank.sv
// Shadow and active duty/sign registers for all channels.
// Writes land in the shadow copy; the active copy loads at a period
// boundary. Two dual-mode partners load only when both have pending writes.
// Assumes: NCH is even; partner of channel c is c^1.
module hbp_duty_bank
    import hbp_pkg::*;
#(
    parameter int NCH    = 2,
    parameter int DUTY_W = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wrap,
    input  logic [NCH-1:0]             wr_duty,
    input  logic [DUTY_W:0]            wr_val,
    input  logic [NCH-1:0][1:0]        mode_q,
    output logic [NCH-1:0][DUTY_W:0]   act_q
);
    logic [NCH-1:0][DUTY_W:0] shadow_q;
    logic [NCH-1:0]           pend_q;
    logic [NCH-1:0]           load;

    // Decides per channel whether the active copy loads at this boundary.
    always_comb begin
        for (int c = 0; c < NCH; c++) begin
            load[c] = wrap && pend_q[c] &&
                      ((mode_q[c] != HB_DUAL) || (mode_q[c ^ 1] != HB_DUAL) ||
                       pend_q[c ^ 1]);
        end
    end

    // Holds shadow, pending flag and active copy for every channel.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shadow_q <= '0;
            pend_q   <= '0;
            act_q    <= '0;
        end else begin
            for (int c = 0; c < NCH; c++) begin
                if (wr_duty[c]) shadow_q[c] <= wr_val;
                if (load[c])    act_q[c]    <= shadow_q[c];
                if (wr_duty[c]) pend_q[c]   <= 1'b1;
                else if (load[c]) pend_q[c] <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/hbp_pin_steer.sv
// Output steering for one channel: compares the counter with the duty,
// then routes the waveform and the static level to the plus/minus pins.
// Assumes: released pins drive low with their enable low.
module hbp_pin_steer
    import hbp_pkg::*;
#(
    parameter int DUTY_W = 8
) (
    input  logic [1:0]        mode,
    input  logic              recirc,
    input  logic              sign,
    input  logic [DUTY_W-1:0] mag,
    input  logic [DUTY_W-1:0] cnt,
    output logic              pin_p,
    output logic              pin_m,
    output logic              oe_p,
    output logic              oe_m
);
    logic raw;
    logic wave;

    // Raw PWM and polarity-adjusted waveform.
    assign raw  = (cnt < mag);
    assign wave = raw ^ recirc;

    // Selects pin levels and enables from the mode.
    always_comb begin
        pin_p = 1'b0;
        pin_m = 1'b0;
        oe_p  = 1'b0;
        oe_m  = 1'b0;
        case (mode)
            HB_HALF: begin
                pin_p = raw;
                oe_p  = 1'b1;
            end
            HB_FULL, HB_DUAL: begin
                oe_p  = 1'b1;
                oe_m  = 1'b1;
                pin_p = sign ? recirc : wave;
                pin_m = sign ? wave : recirc;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/hbridge_pwm_pair.sv
// H-bridge PWM channel pair(s): register write port, shared timebase,
// double-buffered duty bank and per-channel pin steering.
// Assumes: DUTY_W >= 2 so that control fields fit in wr_data.
module hbridge_pwm_pair
    import hbp_pkg::*;
#(
    parameter int NPAIR  = 1,
    parameter int DUTY_W = 8,
    localparam int NCH   = 2 * NPAIR,
    localparam int CH_AW = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic [CH_AW:0]  wr_addr,
    input  logic [DUTY_W:0] wr_data,
    output logic [NCH-1:0]  pin_p,
    output logic [NCH-1:0]  pin_m,
    output logic [NCH-1:0]  oe_p,
    output logic [NCH-1:0]  oe_m
);
    logic [DUTY_W-1:0]        cnt_q;
    logic                     wrap;
    logic [NCH-1:0][1:0]      mode_q;
    logic [NCH-1:0]           recirc_q;
    logic [NCH-1:0]           wr_ctrl;
    logic [NCH-1:0]           wr_duty;
    logic [NCH-1:0][DUTY_W:0] act_q;

    // Decodes the write address into per-channel strobes.
    always_comb begin
        for (int c = 0; c < NCH; c++) begin
            wr_ctrl[c] = wr_en && !wr_addr[CH_AW] && (wr_addr[CH_AW-1:0] == c[CH_AW-1:0]);
            wr_duty[c] = wr_en &&  wr_addr[CH_AW] && (wr_addr[CH_AW-1:0] == c[CH_AW-1:0]);
        end
    end

    // Mode and recirculation registers, effective right after the write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q   <= '0;
            recirc_q <= '0;
        end else begin
            for (int c = 0; c < NCH; c++) begin
                if (wr_ctrl[c]) begin
                    mode_q[c]   <= wr_data[1:0];
                    recirc_q[c] <= wr_data[2];
                end
            end
        end
    end

    hbp_timebase #(.W(DUTY_W)) u_tb (
        .clk   (clk),
        .rst_n (rst_n),
        .cnt_q (cnt_q),
        .wrap  (wrap)
    );

    hbp_duty_bank #(.NCH(NCH), .DUTY_W(DUTY_W)) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .wrap    (wrap),
        .wr_duty (wr_duty),
        .wr_val  (wr_data),
        .mode_q  (mode_q),
        .act_q   (act_q)
    );

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        hbp_pin_steer #(.DUTY_W(DUTY_W)) u_steer (
            .mode   (mode_q[c]),
            .recirc (recirc_q[c]),
            .sign   (act_q[c][DUTY_W]),
            .mag    (act_q[c][DUTY_W-1:0]),
            .cnt    (cnt_q),
            .pin_p  (pin_p[c]),
            .pin_m  (pin_m[c]),
            .oe_p   (oe_p[c]),
            .oe_m   (oe_m[c])
        );
    end
endmodule

// File: rtl/hbp_checker.sv
// Property checker for hbridge_pwm_pair, attached by bind below.
module hbp_checker
    import hbp_pkg::*;
#(
    parameter int NCH    = 2,
    parameter int DUTY_W = 8
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic [NCH-1:0]           pin_p,
    input logic [NCH-1:0]           pin_m,
    input logic [NCH-1:0]           oe_p,
    input logic [NCH-1:0]           oe_m,
    input logic [DUTY_W-1:0]        cnt_q,
    input logic [NCH-1:0][1:0]      mode_q,
    input logic [NCH-1:0]           recirc_q,
    input logic [NCH-1:0][DUTY_W:0] act_q
);
    localparam logic [DUTY_W-1:0] CNT_MAX = {DUTY_W{1'b1}};

    AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q != CNT_MAX) |=> (cnt_q == DUTY_W'($past(cnt_q) + 1'b1))); // R3
    AST_CNT_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q == CNT_MAX) |=> (cnt_q == '0)); // R3

    for (genvar c = 0; c < NCH; c++) begin : g_chk
        AST_OFF_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
            (mode_q[c] == HB_OFF) |-> (!oe_p[c] && !oe_m[c] && !pin_p[c] && !pin_m[c])); // R2
        AST_HALF_MINUS_FREE: assert property (@(posedge clk) disable iff (!rst_n)
            (mode_q[c] == HB_HALF) |-> (oe_p[c] && !oe_m[c] && !pin_m[c])); // R6
        AST_BRIDGE_DRIVEN: assert property (@(posedge clk) disable iff (!rst_n)
            mode_q[c][1] |-> (oe_p[c] && oe_m[c])); // R4
        AST_STATIC_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
            mode_q[c][1] |-> ((act_q[c][DUTY_W] ? pin_p[c] : pin_m[c]) == recirc_q[c])); // R5
        AST_ACTIVE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
            (cnt_q != CNT_MAX) |=> $stable(act_q[c])); // R7
    end
endmodule

bind hbridge_pwm_pair hbp_checker #(.NCH(NCH), .DUTY_W(DUTY_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .pin_p    (pin_p),
    .pin_m    (pin_m),
    .oe_p     (oe_p),
    .oe_m     (oe_m),
    .cnt_q    (cnt_q),
    .mode_q   (mode_q),
    .recirc_q (recirc_q),
    .act_q    (act_q)
);

// File: tb/hbridge_pwm_pair_test.sv
`timescale 1ns/1ps
module hbridge_pwm_pair_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [1:0] wr_addr = '0;
    logic [8:0] wr_data = '0;
    logic [1:0] pin_p, pin_m, oe_p, oe_m;
    logic [7:0] bcnt;
    int n_tests = 0;
    int n_fail  = 0;

    hbridge_pwm_pair uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .pin_p(pin_p), .pin_m(pin_m), .oe_p(oe_p), .oe_m(oe_m)
    );

    always #5 clk = ~clk;

    // Bench model of the period counter (R3): 0 after reset, +1 per edge.
    always @(posedge clk) begin
        if (!rst_n) bcnt <= 8'd0;
        else        bcnt <= bcnt + 8'd1;
    end

    task automatic check(input string req, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    task automatic wr_now(input logic [1:0] a, input logic [8:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic wr(input logic [1:0] a, input logic [8:0] d);
        @(negedge clk);
        wr_now(a, d);
    endtask

    task automatic wait_phase(input logic [7:0] p);
        @(negedge clk);
        while (bcnt != p) @(negedge clk);
    endtask

    task automatic settle();
        wait_phase(8'd0);
        wait_phase(8'd0);
    endtask

    task automatic measure(input int ch, output int np, output int nm,
                           output int ep, output int em);
        np = 0; nm = 0; ep = 0; em = 0;
        for (int i = 0; i < 256; i++) begin
            @(negedge clk);
            np += int'(pin_p[ch]); nm += int'(pin_m[ch]);
            ep += int'(oe_p[ch]);  em += int'(oe_m[ch]);
        end
    endtask

    initial begin
        #1_900_000;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        int np, nm, ep, em, d, wv, st;
        // R1: reset state
        repeat (4) @(negedge clk);
        check("R1 pins in reset", int'({pin_p, pin_m}), 0);
        check("R1 enables in reset", int'({oe_p, oe_m}), 0);
        rst_n = 1'b1;
        // R1/R2: after reset, channels disabled with a duty loaded
        wr(2'd2, 9'd100);
        settle();
        measure(0, np, nm, ep, em);
        check("R2 disabled ch0 activity", np + nm + ep + em, 0);

        // R3 R4 R5: full-bridge sweep on channel 0
        for (int r = 0; r < 2; r++) begin
            for (int s = 0; s < 2; s++) begin
                for (int k = 0; k < 18; k++) begin
                    d = (k < 16) ? k * 17 : ((k == 16) ? 1 : 128);
                    wr(2'd0, {6'd0, r[0], 2'b10});
                    wr(2'd2, {s[0], d[7:0]});
                    settle();
                    measure(0, np, nm, ep, em);
                    wv = (r != 0) ? 256 - d : d;
                    st = (r != 0) ? 256 : 0;
                    check("R3/R5 waveform pin high count", (s != 0) ? nm : np, wv);
                    check("R4/R5 static pin high count", (s != 0) ? np : nm, st);
                    check("R4 enables high", ep + em, 512);
                end
            end
        end

        // R10 baseline on ch0, then R6 half-bridge sweep on ch1
        wr(2'd0, 9'b000_000_010);
        wr(2'd2, 9'd77);
        for (int k = 0; k < 18; k++) begin
            d = (k < 16) ? k * 17 : ((k == 16) ? 1 : 128);
            wr(2'd1, 9'b000_000_101);       // half mode, recirc set
            wr(2'd3, {1'b1, d[7:0]});       // sign set
            settle();
            measure(1, np, nm, ep, em);
            check("R6 half plus count", np, d);
            check("R6 half minus count", nm, 0);
            check("R6 half plus enable", ep, 256);
            check("R6 half minus enable", em, 0);
        end
        measure(0, np, nm, ep, em);
        check("R10 ch0 untouched plus", np, 77);
        check("R10 ch0 untouched minus", nm, 0);

        // R2: disable ch1 with a nonzero duty
        wr(2'd1, 9'd0);
        check("R2 ch1 released next cycle", int'({oe_p[1], oe_m[1], pin_p[1], pin_m[1]}), 0);
        measure(1, np, nm, ep, em);
        check("R2 ch1 disabled activity", np + nm + ep + em, 0);

        // R7: write lands at the next period start only
        wr(2'd2, 9'd200);
        settle();
        wait_phase(8'd100);
        wr_now(2'd2, 9'd50);
        wait_phase(8'd120);
        check("R7 old duty before boundary", int'(pin_p[0]), 1);
        wait_phase(8'd0);
        check("R7 new duty at counter 0", int'(pin_p[0]), 1);
        wait_phase(8'd49);
        check("R7 new duty at 49", int'(pin_p[0]), 1);
        @(negedge clk);
        check("R7 new duty at 50", int'(pin_p[0]), 0);
        wait_phase(8'd120);
        check("R7 new duty at 120", int'(pin_p[0]), 0);

        // R9: mode/recirc take effect right after the write
        wr(2'd2, 9'd0);
        settle();
        check("R9 before recirc write", int'({pin_p[0], pin_m[0]}), 0);
        wr_now(2'd0, 9'b000_000_110);
        check("R9 after recirc write", int'({pin_p[0], pin_m[0]}), 3);

        // R8: dual mode pair update
        wr(2'd0, 9'b000_000_011);
        wr(2'd1, 9'b000_000_011);
        wr(2'd2, 9'd100);
        wr(2'd3, 9'd100);
        settle();
        wr(2'd2, {1'b1, 8'd10});
        settle();
        measure(0, np, nm, ep, em);
        check("R8 lone write held plus", np, 100);
        check("R8 lone write held minus", nm, 0);
        wait_phase(8'd20);
        wr_now(2'd3, 9'd60);
        wait_phase(8'd70);
        check("R8 ch0 old before boundary", int'(pin_p[0]), 1);
        check("R8 ch1 old before boundary", int'(pin_p[1]), 1);
        wait_phase(8'd5);
        check("R8 ch0 minus carries new", int'(pin_m[0]), 1);
        wait_phase(8'd70);
        check("R8 ch0 new after boundary", int'(pin_p[0]), 0);
        check("R8 ch1 new after boundary", int'(pin_p[1]), 0);
        measure(1, np, nm, ep, em);
        check("R8 ch1 new duty count", np, 60);

        summary();
    end
endmodule